// File: doc/BRIEF.md
# Saturating Trim Counter with Nonvolatile Recall

This block keeps a 7-bit trim code that sets the level of a current-output DAC. A control decoder sends it single-cycle up and down strobes. Each accepted strobe moves the code by one step. At code 127 an up strobe leaves the code where it is, and at code 0 a down strobe does the same, so the code never wraps.

After reset the block reads the saved code from a nonvolatile register and loads its counter with that value. Until that read finishes, the output is marked invalid. A program request writes the current code to the store and then reads it back to confirm it. While a read or write is in progress the code is frozen. Each store operation has a cycle limit. An operation that overruns the limit is abandoned and reported as an error.

Top module: `trim_ctr_top`

## Requirements
- R1: While the power-up recall is pending, `valid_o` is 0 and up/down strobes are ignored. When the read acknowledge arrives, `setting_o` takes the value on `nv_rdata_i` and `valid_o` goes to 1.
- R2: While valid and idle, an up strobe on its own raises `setting_o` by one on the next clock edge, and a down strobe on its own lowers it by one. Both strobes together, or neither, leave the code unchanged.
- R3: At code 127 an up strobe leaves the code at 127.
- R4: At code 0 a down strobe leaves the code at 0.
- R5: A program request accepted while idle raises `busy_o` from the next cycle and writes the current code on `nv_wdata_o` with `nv_wr_o` held high until acknowledged. At the end, `done_o` pulses for one cycle as `busy_o` falls.
- R6: Up/down strobes received while `busy_o` is high are dropped, and `setting_o` does not change during a store. A strobe in the same cycle as an accepted program request is also dropped.
- R7: A program request received while `busy_o` is high is ignored and starts no second write.
- R8: After the write, the block reads the store back. If the value read differs from the written code, `err_o` is set. `err_o` then holds until the next program request is accepted, which clears it.
- R9: If a store is not finished within `STORE_TMO_CYC` cycles of its start, it is abandoned: `done_o` still pulses and `err_o` is set.
- R10: If the recall read gets no acknowledge within `STORE_TMO_CYC` cycles, the code becomes the default mid-scale value 0x40, `err_o` is set and `valid_o` goes to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc_i | input | 1 | Up strobe |
| dec_i | input | 1 | Down strobe |
| prog_i | input | 1 | Request to save the current code |
| nv_rd_o | output | 1 | Read request to the nonvolatile register |
| nv_wr_o | output | 1 | Write request to the nonvolatile register |
| nv_wdata_o | output | 7 | Data to write |
| nv_rdata_i | input | 7 | Stored value |
| nv_ack_i | input | 1 | One-cycle completion of the pending read or write |
| setting_o | output | 7 | Trim code to the DAC |
| valid_o | output | 1 | Code has been recalled |
| busy_o | output | 1 | Store in progress |
| done_o | output | 1 | One-cycle pulse when a store ends |
| err_o | output | 1 | Recall, store or verify failure |

## Verification
The hardest cases are the failures. A read-back mismatch happens only if the stored cell differs from the written code. A timeout needs a store that never answers. A default recall needs an absent store at power-up. To reach these, the bench's nonvolatile model can flip a bit on write or stop acknowledging. The model's contents are preset before each reset, so the recalled code starts next to either end and saturation takes only a few strobes.

// File: rtl/trim_ctr_pkg.sv
package trim_ctr_pkg;
  typedef enum logic [2:0] {
    ST_BOOT,
    ST_RECALL,
    ST_IDLE,
    ST_WRITE,
    ST_VERIFY
  } nv_state_e;

  typedef enum logic [1:0] {
    CNT_HOLD,
    CNT_UP,
    CNT_DOWN,
    CNT_LOAD
  } cnt_op_e;
endpackage

// File: rtl/trim_rst_sync.sv
module trim_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else         sync_q[i] <= 1'b1;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else         sync_q[i] <= sync_q[i-1];
      end
    end
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/trim_sat_counter.sv
module trim_sat_counter
  import trim_ctr_pkg::*;
#(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cnt_op_e      op_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] value_o
);
  localparam logic [W-1:0] MAX_CODE = {W{1'b1}};
  localparam logic [W-1:0] MIN_CODE = '0;

  logic [W-1:0] val_q;
  logic [W-1:0] val_d;
  logic         val_en;

  always_comb begin
    val_d  = val_q;
    val_en = 1'b0;
    unique case (op_i)
      CNT_UP: begin
        if (val_q != MAX_CODE) begin
          val_d  = val_q + 1'b1;
          val_en = 1'b1;
        end
      end
      CNT_DOWN: begin
        if (val_q != MIN_CODE) begin
          val_d  = val_q - 1'b1;
          val_en = 1'b1;
        end
      end
      CNT_LOAD: begin
        val_d  = load_val_i;
        val_en = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= '0;
    else if (val_en) val_q <= val_d;
  end

  assign value_o = val_q;
endmodule

// File: rtl/trim_nv_seq.sv
module trim_nv_seq
  import trim_ctr_pkg::*;
#(
  parameter int           W             = 7,
  parameter int           STORE_TMO_CYC = 20_000_000,
  parameter logic [W-1:0] DEFAULT_CODE  = 7'h40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         prog_i,
  input  logic         nv_ack_i,
  input  logic [W-1:0] nv_rdata_i,
  input  logic [W-1:0] cur_val_i,
  output logic         nv_rd_o,
  output logic         nv_wr_o,
  output logic [W-1:0] nv_wdata_o,
  output logic         load_o,
  output logic [W-1:0] load_val_o,
  output logic         count_ok_o,
  output logic         valid_o,
  output logic         busy_o,
  output logic         done_o,
  output logic         err_o
);
  localparam int TMO_W = $clog2(STORE_TMO_CYC + 1);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(STORE_TMO_CYC - 1);

  nv_state_e    state_q, state_d;
  logic [W-1:0] snap_q, snap_d;
  logic         snap_en;
  logic         err_q, err_d;
  logic         done_q, done_d;
  logic [TMO_W-1:0] tmo_q, tmo_d;
  logic         tmo_en;
  logic         tmo_hit;

  // timer: cleared while idle, runs across a whole operation
  assign tmo_hit = (tmo_q == TMO_LAST);

  always_comb begin
    tmo_en = 1'b1;
    tmo_d  = tmo_q;
    if (state_q == ST_IDLE || state_q == ST_BOOT) begin
      tmo_d = '0;
    end else if (!tmo_hit) begin
      tmo_d = tmo_q + 1'b1;
    end else begin
      tmo_en = 1'b0;
    end
  end

  always_comb begin
    state_d    = state_q;
    snap_d     = snap_q;
    snap_en    = 1'b0;
    err_d      = err_q;
    done_d     = 1'b0;
    load_o     = 1'b0;
    load_val_o = nv_rdata_i;
    nv_rd_o    = 1'b0;
    nv_wr_o    = 1'b0;
    unique case (state_q)
      ST_BOOT: state_d = ST_RECALL;
      ST_RECALL: begin
        nv_rd_o = 1'b1;
        if (nv_ack_i) begin
          load_o  = 1'b1;
          state_d = ST_IDLE;
        end else if (tmo_hit) begin
          load_o     = 1'b1;
          load_val_o = DEFAULT_CODE;
          err_d      = 1'b1;
          state_d    = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (prog_i) begin
          snap_d  = cur_val_i;
          snap_en = 1'b1;
          err_d   = 1'b0;
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        nv_wr_o = 1'b1;
        if (nv_ack_i) begin
          state_d = ST_VERIFY;
        end else if (tmo_hit) begin
          err_d   = 1'b1;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_VERIFY: begin
        nv_rd_o = 1'b1;
        if (nv_ack_i) begin
          err_d   = (nv_rdata_i != snap_q);
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (tmo_hit) begin
          err_d   = 1'b1;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_BOOT;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_q <= '0;
    else if (snap_en) snap_q <= snap_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmo_q <= '0;
    else if (tmo_en) tmo_q <= tmo_d;
  end

  assign nv_wdata_o = snap_q;
  assign valid_o    = (state_q == ST_IDLE) || (state_q == ST_WRITE) || (state_q == ST_VERIFY);
  assign busy_o     = (state_q == ST_WRITE) || (state_q == ST_VERIFY);
  assign count_ok_o = (state_q == ST_IDLE) && !prog_i;
  assign done_o     = done_q;
  assign err_o      = err_q;
endmodule

// File: rtl/trim_ctr_top.sv
module trim_ctr_top
  import trim_ctr_pkg::*;
#(
  parameter int           W             = 7,
  parameter int           STORE_TMO_CYC = 20_000_000,
  parameter logic [W-1:0] DEFAULT_CODE  = 7'h40,
  parameter int           RST_STAGES    = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         dec_i,
  input  logic         prog_i,
  output logic         nv_rd_o,
  output logic         nv_wr_o,
  output logic [W-1:0] nv_wdata_o,
  input  logic [W-1:0] nv_rdata_i,
  input  logic         nv_ack_i,
  output logic [W-1:0] setting_o,
  output logic         valid_o,
  output logic         busy_o,
  output logic         done_o,
  output logic         err_o
);
  logic         rst_sync_n;
  logic         load;
  logic [W-1:0] load_val;
  logic         count_ok;
  cnt_op_e      cnt_op;

  trim_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  trim_nv_seq #(
    .W             (W),
    .STORE_TMO_CYC (STORE_TMO_CYC),
    .DEFAULT_CODE  (DEFAULT_CODE)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .prog_i     (prog_i),
    .nv_ack_i   (nv_ack_i),
    .nv_rdata_i (nv_rdata_i),
    .cur_val_i  (setting_o),
    .nv_rd_o    (nv_rd_o),
    .nv_wr_o    (nv_wr_o),
    .nv_wdata_o (nv_wdata_o),
    .load_o     (load),
    .load_val_o (load_val),
    .count_ok_o (count_ok),
    .valid_o    (valid_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  always_comb begin
    cnt_op = CNT_HOLD;
    if (load)                         cnt_op = CNT_LOAD;
    else if (count_ok && inc_i && !dec_i) cnt_op = CNT_UP;
    else if (count_ok && dec_i && !inc_i) cnt_op = CNT_DOWN;
  end

  trim_sat_counter #(.W(W)) cnt_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .op_i       (cnt_op),
    .load_val_i (load_val),
    .value_o    (setting_o)
  );
endmodule

// File: rtl/trim_ctr_chk.sv
module trim_ctr_chk #(
  parameter int W   = 7,
  parameter int TMO = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         inc_i,
  input logic         dec_i,
  input logic         prog_i,
  input logic         nv_wr_o,
  input logic [W-1:0] nv_wdata_o,
  input logic [W-1:0] setting_o,
  input logic         valid_o,
  input logic         busy_o,
  input logic         done_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam int CW = $clog2(TMO + 2) + 1;

  logic [CW-1:0] busy_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_run_q <= '0;
    else if (busy_o) busy_run_q <= busy_run_q + 1'b1;
    else             busy_run_q <= '0;
  end

  p_quiet_recall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (!busy_o && !nv_wr_o));

  p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !busy_o && !prog_i && inc_i && !dec_i && setting_o != TOP)
    |=> setting_o == $past(setting_o) + 1'b1);

  p_step_dn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !busy_o && !prog_i && dec_i && !inc_i && setting_o != '0)
    |=> setting_o == $past(setting_o) - 1'b1);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && setting_o == TOP && !dec_i) |=> setting_o == TOP);

  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && setting_o == '0 && !inc_i) |=> setting_o == '0);

  p_wdata_r5: assert property (@(posedge clk) disable iff (!rst_n)
    nv_wr_o |-> nv_wdata_o == setting_o);

  p_done_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(setting_o));

  p_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run_q <= CW'(TMO));
endmodule

bind trim_ctr_top trim_ctr_chk #(.W(W), .TMO(STORE_TMO_CYC)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .inc_i      (inc_i),
  .dec_i      (dec_i),
  .prog_i     (prog_i),
  .nv_wr_o    (nv_wr_o),
  .nv_wdata_o (nv_wdata_o),
  .setting_o  (setting_o),
  .valid_o    (valid_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/trim_ctr_tb.sv
`timescale 1ns/1ps
module trim_ctr_top_tb_top;
  localparam int W      = 7;
  localparam int TMO    = 40;
  localparam int NV_LAT = 6;
  localparam int NVEC   = 12;

  // vector: [8:7] op (0 none, 1 up, 2 down, 3 both), [6:0] expected code
  localparam logic [8:0] VEC [NVEC] = '{
    {2'd1, 7'h41}, {2'd1, 7'h42}, {2'd2, 7'h41}, {2'd3, 7'h41},
    {2'd0, 7'h41}, {2'd2, 7'h40}, {2'd2, 7'h3F}, {2'd1, 7'h40},
    {2'd1, 7'h41}, {2'd1, 7'h42}, {2'd3, 7'h42}, {2'd2, 7'h41}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic inc_i, dec_i, prog_i;
  logic nv_rd_o, nv_wr_o, nv_ack_i;
  logic [W-1:0] nv_wdata_o, nv_rdata_i, setting_o;
  logic valid_o, busy_o, done_o, err_o;

  logic [W-1:0] nv_mem;
  logic         mute, corrupt;
  int           lat_cnt;
  int           wr_count;
  int           n_vec = 0;
  int           n_bad = 0;
  bit           finished = 0;

  always #2.5 clk = ~clk;

  trim_ctr_top #(.STORE_TMO_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .inc_i(inc_i), .dec_i(dec_i), .prog_i(prog_i),
    .nv_rd_o(nv_rd_o), .nv_wr_o(nv_wr_o), .nv_wdata_o(nv_wdata_o),
    .nv_rdata_i(nv_rdata_i), .nv_ack_i(nv_ack_i), .setting_o(setting_o),
    .valid_o(valid_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  // nonvolatile register model
  assign nv_rdata_i = nv_mem;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_ack_i <= 1'b0;
      lat_cnt  <= 0;
    end else if ((nv_rd_o || nv_wr_o) && !nv_ack_i && !mute) begin
      if (lat_cnt == NV_LAT - 1) begin
        nv_ack_i <= 1'b1;
        lat_cnt  <= 0;
        if (nv_wr_o) begin
          nv_mem   <= corrupt ? (nv_wdata_o ^ 7'h01) : nv_wdata_o;
          wr_count <= wr_count + 1;
        end
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end else begin
      nv_ack_i <= 1'b0;
      lat_cnt  <= 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [1:0] op);
    @(negedge clk);
    inc_i = op[0];
    dec_i = op[1];
    @(negedge clk);
    inc_i = 1'b0;
    dec_i = 1'b0;
  endtask

  task automatic do_reset(input logic [W-1:0] preset);
    nv_mem = preset;
    rst_n  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_valid(input int lim);
    for (int i = 0; i < lim && !valid_o; i++) @(negedge clk);
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done_o && cyc < 4 * TMO) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic program_once;
    @(negedge clk);
    prog_i = 1'b1;
    @(negedge clk);
    prog_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int cyc;
    inc_i = 0; dec_i = 0; prog_i = 0;
    mute = 0; corrupt = 0; wr_count = 0;
    nv_mem = 7'h40;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 valid in reset", valid_o, 0);
    chk("R1 busy in reset", busy_o, 0);
    rst_n = 1'b1;

    // R1: strobes during recall are ignored
    inc_i = 1'b1;
    wait_valid(100);
    inc_i = 1'b0;
    chk("R1 valid after recall", valid_o, 1);
    @(negedge clk);
    chk("R1 recalled code", setting_o, 'h40);
    chk("R1 no error", err_o, 0);

    // R2: vector table
    for (int v = 0; v < NVEC; v++) begin
      strobe(VEC[v][8:7]);
      chk($sformatf("R2 vector %0d", v), setting_o, VEC[v][6:0]);
    end

    // R5/R6/R7: program, with strobes and a second request during busy
    program_once();
    chk("R5 busy after request", busy_o, 1);
    strobe(2'd1);
    chk("R6 code frozen during busy", setting_o, 'h41);
    program_once();
    strobe(2'd2);
    wait_done(cyc);
    chk("R5 done pulse", done_o, 1);
    chk("R5 stored value", nv_mem, 'h41);
    chk("R6 code after store", setting_o, 'h41);
    chk("R8 verify ok", err_o, 0);
    repeat (5) @(negedge clk);
    chk("R7 no second store busy", busy_o, 0);
    chk("R7 single write", wr_count, 1);

    // R8: read-back mismatch, then cleared by next store
    corrupt = 1'b1;
    program_once();
    wait_done(cyc);
    @(negedge clk);
    chk("R8 mismatch error", err_o, 1);
    corrupt = 1'b0;
    program_once();
    chk("R8 error cleared on accept", err_o, 0);
    wait_done(cyc);
    @(negedge clk);
    chk("R8 clean verify", err_o, 0);

    // R9: store timeout
    mute = 1'b1;
    program_once();
    wait_done(cyc);
    chk("R9 done after timeout", done_o, 1);
    chk("R9 bounded time", int'(cyc <= TMO + 2), 1);
    @(negedge clk);
    chk("R9 error set", err_o, 1);
    mute = 1'b0;

    // R3: saturation at the top
    do_reset(7'h7D);
    wait_valid(100);
    @(negedge clk);
    strobe(2'd1); chk("R3 step to 7E", setting_o, 'h7E);
    strobe(2'd1); chk("R3 step to 7F", setting_o, 'h7F);
    strobe(2'd1); chk("R3 hold at 7F", setting_o, 'h7F);
    strobe(2'd1); chk("R3 hold at 7F again", setting_o, 'h7F);

    // R4: saturation at the bottom
    do_reset(7'h02);
    wait_valid(100);
    @(negedge clk);
    strobe(2'd2); chk("R4 step to 01", setting_o, 'h01);
    strobe(2'd2); chk("R4 step to 00", setting_o, 'h00);
    strobe(2'd2); chk("R4 hold at 00", setting_o, 'h00);
    strobe(2'd1); chk("R4 leave zero", setting_o, 'h01);

    // R10: recall without response
    mute = 1'b1;
    do_reset(7'h11);
    wait_valid(TMO + 20);
    @(negedge clk);
    chk("R10 valid after default", valid_o, 1);
    chk("R10 default code", setting_o, 'h40);
    chk("R10 error set", err_o, 1);
    mute = 1'b0;

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule